// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Break Detection

This block turns a single asynchronous serial line into characters. The line passes through a two-stage synchroniser. A strobe, supplied from outside at sixteen times the bit rate, then samples it. The receiver finds the falling edge of a start bit. It confirms that the line is still low at the centre of that bit, then takes each later bit at the centre of its sixteen-tick cell. Characters of five to eight data bits are assembled least significant bit first. An optional parity bit follows them, and then one stop bit.

When a character is complete, the block raises a one-cycle valid strobe. The character and its parity-error, framing-error and break flags are valid in that same cycle, so a downstream FIFO can capture them without further handshake. A line held low through a whole character, stop bit included, is reported as a break. After a break the receiver ignores the line until it goes high again. A low stop bit on any other character counts as a framing error, and that low bit is reused at once as the start bit of the next character.

Top module: `uart_rx_brk`

## Requirements
- R1: While `rst_ni` is low, all outputs are 0. A frame that was cut off by reset produces no character, and the next full frame after reset is received correctly.
- R2: A falling edge is accepted as a start bit only if the synchronised line is still low at tick 7 of the start cell. Ticks are counted 0 to 15, with tick 0 being the tick that saw the line low. If the line is high at tick 7, the receiver goes back to idle and emits nothing.
- R3: `word_len_i` sets the number of data bits as 5 + `word_len_i` (0 gives 5 bits, 3 gives 8 bits). Data arrives LSB first. Bit k of the line goes to `char_data_o[k]`, and bits at or above the word length read 0.
- R4: `parity_mode_i` selects the parity mode: 0 none, 1 odd, 2 even, 3 parity bit always 1, 4 parity bit always 0. Codes 5 to 7 behave as none. When parity is enabled, `par_err_o` is 1 exactly when the received parity bit differs from the expected bit. With parity off, `par_err_o` stays 0.
- R5: A character whose stop-bit sample is 0, and which is not a break, is delivered with `frame_err_o` = 1 and `break_o` = 0.
- R6: After a framing error, the low stop bit serves as the start bit of the next character. The next data cell begins 8 ticks after the stop-bit sample.
- R7: If the start, data, parity and stop samples are all 0, a break is reported. It is a single character with `char_data_o` = 0, `break_o` = 1, `frame_err_o` = 1 and `par_err_o` = 0.
- R8: After a break, no start bit is accepted and no character is produced while the line stays low. The receiver becomes idle on the first tick that sees the line high.
- R9: Each character gives exactly one single-cycle `char_valid_o` pulse, registered one clock after the tick that samples the stop bit. Data and flags are valid in that same cycle.
- R10: Bit timing advances only on cycles with `tick_i` = 1. With `tick_i` held low, line activity has no effect, and a frame paused by withheld ticks still decodes correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Oversample strobe, 16 per bit time |
| rx_i | input | 1 | Asynchronous serial line, idle high |
| word_len_i | input | 2 | Data bits minus 5 |
| parity_mode_i | input | 3 | Parity mode code |
| char_valid_o | output | 1 | One-cycle pulse per received character |
| char_data_o | output | DATA_W | Received character |
| par_err_o | output | 1 | Parity mismatch on this character |
| frame_err_o | output | 1 | Stop bit sampled low |
| break_o | output | 1 | Character is a break event |

## Verification
The bench aims at the points where a receiver slips by a bit or a cycle, and compares every output against a tick-counting reference model on every clock.

- **Framing-error resync.** A framing error is followed directly by the data bits of a second character with no start bit of its own. A design that hunted for a new edge would lose or shift that character, and one that reloaded its timer at the wrong phase would shift it by half a bit.
- **Break handling.** A long low line has to produce exactly one zeroed character with both flags set. A receiver that re-armed during the low period would emit a stream of breaks or framing errors.
- **Start glitches.** A short low pulse has to produce nothing, which shows whether the mid-start check is missing.
- **Parity and word length.** Each parity code is driven with both a matching and a wrong parity bit, including the unused codes. Every word length is driven with ones above its width, which would show up in the upper data bits if masking were wrong.
- **Tick gating.** Withheld ticks and a reset in mid-frame must leave no trace.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  localparam int MIN_WORD = 5;

  localparam logic [2:0] PAR_NONE  = 3'd0;
  localparam logic [2:0] PAR_ODD   = 3'd1;
  localparam logic [2:0] PAR_EVEN  = 3'd2;
  localparam logic [2:0] PAR_MARK  = 3'd3;
  localparam logic [2:0] PAR_SPACE = 3'd4;

  typedef enum logic [2:0] {
    S_IDLE,
    S_START,
    S_DATA,
    S_PAR,
    S_STOP,
    S_BRK
  } rx_state_e;

endpackage

// File: rtl/rx_sync.sv
module rx_sync #(
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= {STAGES{RESET_VAL}};
    else         chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/rx_bit_timer.sv
module rx_bit_timer #(
  parameter int OSR = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic load_i,
  input  logic resync_i,
  output logic mid_o,
  output logic last_o
);

  localparam int CW = $clog2(OSR);
  localparam logic [CW-1:0] MID  = CW'(OSR / 2 - 1);
  localparam logic [CW-1:0] LAST = CW'(OSR - 1);

  logic [CW-1:0] cnt_q;

  // start detect tick is tick 0, so the next one is tick 1; resync resumes just past mid
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= resync_i ? MID + 1'b1 : CW'(1);
    else if (tick_i)        cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
  end

  assign mid_o  = tick_i && (cnt_q == MID);
  assign last_o = tick_i && (cnt_q == LAST);

  AST_TICK_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !load_i) |=> $stable(cnt_q)); // R10

endmodule

// File: rtl/rx_par_gen.sv
module rx_par_gen
  import uart_rx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] data_i,
  input  logic [2:0]        mode_i,
  output logic              en_o,
  output logic              bit_o
);

  always_comb begin
    en_o  = 1'b1;
    bit_o = 1'b0;
    case (mode_i)
      PAR_ODD:   bit_o = ~(^data_i);
      PAR_EVEN:  bit_o = ^data_i;
      PAR_MARK:  bit_o = 1'b1;
      PAR_SPACE: bit_o = 1'b0;
      default:   en_o  = 1'b0;
    endcase
  end

endmodule

// File: rtl/uart_rx_brk.sv
module uart_rx_brk
  import uart_rx_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int OSR         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              rx_i,
  input  logic [1:0]        word_len_i,
  input  logic [2:0]        parity_mode_i,
  output logic              char_valid_o,
  output logic [DATA_W-1:0] char_data_o,
  output logic              par_err_o,
  output logic              frame_err_o,
  output logic              break_o
);

  localparam int IDX_W = $clog2(DATA_W);

  rx_state_e         state_q;
  logic [IDX_W-1:0]  bit_idx_q;
  logic [DATA_W-1:0] data_q;
  logic              par_q;
  logic              allz_q;

  logic rx_s, mid, last;
  logic start_det, stop_mid, resync;
  logic par_en, par_exp;
  logic [IDX_W-1:0] idx_last;

  rx_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (rx_i),
    .q_o    (rx_s)
  );

  assign start_det = (state_q == S_IDLE) && tick_i && !rx_s;
  assign stop_mid  = (state_q == S_STOP) && mid;
  assign resync    = stop_mid && !rx_s && !allz_q;
  assign idx_last  = IDX_W'(MIN_WORD - 1) + IDX_W'(word_len_i);

  rx_bit_timer #(.OSR(OSR)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick_i),
    .load_i   (start_det || resync),
    .resync_i (resync),
    .mid_o    (mid),
    .last_o   (last)
  );

  rx_par_gen #(.DATA_W(DATA_W)) u_par (
    .data_i (data_q),
    .mode_i (parity_mode_i),
    .en_o   (par_en),
    .bit_o  (par_exp)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= S_IDLE;
      bit_idx_q    <= '0;
      data_q       <= '0;
      par_q        <= 1'b0;
      allz_q       <= 1'b1;
      char_valid_o <= 1'b0;
      char_data_o  <= '0;
      par_err_o    <= 1'b0;
      frame_err_o  <= 1'b0;
      break_o      <= 1'b0;
    end else begin
      char_valid_o <= 1'b0;
      case (state_q)
        S_IDLE: begin
          if (start_det) begin
            state_q <= S_START;
            data_q  <= '0;
            par_q   <= 1'b0;
            allz_q  <= 1'b1;
          end
        end
        S_START: begin
          if (mid && rx_s) begin
            state_q <= S_IDLE;
          end else if (last) begin
            state_q   <= S_DATA;
            bit_idx_q <= '0;
          end
        end
        S_DATA: begin
          if (mid) begin
            data_q[bit_idx_q] <= rx_s;
            if (rx_s) allz_q <= 1'b0;
          end
          if (last) begin
            if (bit_idx_q == idx_last) state_q <= par_en ? S_PAR : S_STOP;
            else                       bit_idx_q <= bit_idx_q + 1'b1;
          end
        end
        S_PAR: begin
          if (mid) begin
            par_q <= rx_s;
            if (rx_s) allz_q <= 1'b0;
          end
          if (last) state_q <= S_STOP;
        end
        S_STOP: begin
          if (mid) begin
            char_valid_o <= 1'b1;
            if (!rx_s && allz_q) begin
              // whole character low: one zeroed break character, then wait for mark
              char_data_o <= '0;
              par_err_o   <= 1'b0;
              frame_err_o <= 1'b1;
              break_o     <= 1'b1;
              state_q     <= S_BRK;
            end else begin
              char_data_o <= data_q;
              par_err_o   <= par_en && (par_q != par_exp);
              frame_err_o <= !rx_s;
              break_o     <= 1'b0;
              if (rx_s) begin
                state_q <= S_IDLE;
              end else begin
                // low stop bit becomes the next start bit, already past its centre
                state_q <= S_START;
                data_q  <= '0;
                par_q   <= 1'b0;
                allz_q  <= 1'b1;
              end
            end
          end
        end
        S_BRK: begin
          if (tick_i && rx_s) state_q <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  AST_VALID_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    char_valid_o |=> !char_valid_o); // R9

  AST_START_REJECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_START && mid && rx_s) |=> (state_q == S_IDLE && !char_valid_o)); // R2

  AST_PAR_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_mid && !par_en) |=> !par_err_o); // R4

  AST_FE_RESYNC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (char_valid_o && frame_err_o && !break_o) |-> (state_q == S_START)); // R6

  AST_BRK_CHAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (char_valid_o && break_o) |-> (char_data_o == '0 && frame_err_o && !par_err_o)); // R7

  AST_BRK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_BRK && !rx_s) |=> (state_q == S_BRK && !char_valid_o)); // R8

endmodule

// File: tb/sim_uart_rx_brk.sv
module sim_uart_rx_brk;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic rx = 1'b1;
  logic [1:0] wl = 2'd3;
  logic [2:0] pm = 3'd0;
  logic       valid;
  logic [7:0] data;
  logic       pe, fe, brk;

  int n_chk = 0;
  int n_err = 0;
  int cyc = 0;
  int tdiv = 1;
  int tcnt = 0;
  bit tick_en = 1'b1;

  always #10 clk = ~clk;

  uart_rx_brk u0 (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .tick_i        (tick),
    .rx_i          (rx),
    .word_len_i    (wl),
    .parity_mode_i (pm),
    .char_valid_o  (valid),
    .char_data_o   (data),
    .par_err_o     (pe),
    .frame_err_o   (fe),
    .break_o       (brk)
  );

  always @(negedge clk) begin
    if (!tick_en) begin
      tick = 1'b0;
      tcnt = 0;
    end else if (tcnt >= tdiv - 1) begin
      tick = 1'b1;
      tcnt = 0;
    end else begin
      tick = 1'b0;
      tcnt = tcnt + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic bit ref_par(input logic [7:0] d, input logic [2:0] m);
    case (m)
      3'd1:    return ~(^d);
      3'd2:    return ^d;
      3'd3:    return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  // reference model: counts ticks from start detection, samples at offset 7 of each 16
  bit q1 = 1'b1, q2 = 1'b1, line;
  int m_mode = 0, m_t = 0;
  bit [7:0] m_data;
  bit m_allz, m_par;
  bit e_valid, e_pe, e_fe, e_brk;
  bit [7:0] e_data;

  always @(posedge clk) begin
    int pos, sub, nb;
    bit pon;
    if (!rst_n) begin
      q1 = 1'b1; q2 = 1'b1; m_mode = 0;
      e_valid = 0; e_data = 0; e_pe = 0; e_fe = 0; e_brk = 0;
    end else begin
      line = q2; q2 = q1; q1 = rx;
      e_valid = 0;
      nb  = 5 + int'(wl);
      pon = (pm >= 3'd1) && (pm <= 3'd4);
      if (tick) begin
        if (m_mode == 0) begin
          if (!line) begin m_mode = 1; m_t = 0; m_data = 0; m_allz = 1; m_par = 0; end
        end else if (m_mode == 2) begin
          if (line) m_mode = 0;
        end else begin
          m_t++;
          pos = m_t / 16;
          sub = m_t % 16;
          if (sub == 7) begin
            if (pos == 0) begin
              if (line) m_mode = 0;
            end else if (pos <= nb) begin
              m_data[pos-1] = line;
              if (line) m_allz = 0;
            end else if (pon && pos == nb + 1) begin
              m_par = line;
              if (line) m_allz = 0;
            end else begin
              e_valid = 1;
              if (!line && m_allz) begin
                e_data = 0; e_pe = 0; e_fe = 1; e_brk = 1; m_mode = 2;
              end else begin
                e_data = m_data;
                e_pe   = pon && (m_par != ref_par(m_data, pm));
                e_fe   = !line;
                e_brk  = 0;
                if (line) m_mode = 0;
                else begin m_t = 7; m_data = 0; m_allz = 1; m_par = 0; end
              end
            end
          end
        end
      end
    end
  end

  logic [10:0] recv[$];

  always @(negedge clk) begin
    if (rst_n) begin
      chk(valid == e_valid, "R9", "valid", valid, e_valid);
      chk(data == e_data, "R3", "data", data, e_data);
      chk(pe == e_pe, "R4", "par_err", pe, e_pe);
      chk(fe == e_fe, "R5", "frame_err", fe, e_fe);
      chk(brk == e_brk, "R7", "break", brk, e_brk);
      if (valid) recv.push_back({brk, fe, pe, data});
    end
  end

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc >= 150000) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      finish_run();
    end
  end

  task automatic hold(input logic v, input int n);
    #1 rx = v;
    repeat (n) begin
      @(posedge clk);
      while (!tick) @(posedge clk);
    end
  endtask

  task automatic send(input logic [7:0] d, input int nb, input bit pen, input bit pv,
                      input bit sv, input bit with_start);
    if (with_start) hold(1'b0, 16);
    for (int i = 0; i < nb; i++) hold(d[i], 16);
    if (pen) hold(pv, 16);
    hold(sv, 16);
  endtask

  task automatic expect_char(input int idx, input logic [7:0] d, input bit p, input bit f,
                             input bit b, input string req);
    if (idx >= recv.size()) begin
      chk(1'b0, req, "char missing", recv.size(), idx + 1);
    end else begin
      chk(recv[idx] == {b, f, p, d}, req, "char", recv[idx], {b, f, p, d});
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    #3 rst_n = 1'b0;
    @(negedge clk);
    #2;
    chk({valid, data, pe, fe, brk} == 12'h0, "R1", "outputs in reset", {valid, data, pe, fe, brk}, 0);
    repeat (3) @(negedge clk);
    #3 rst_n = 1'b1;
  endtask

  initial begin
    logic [7:0] d;
    do_reset();
    hold(1'b1, 20);

    // 8N1 basic
    recv.delete(); wl = 2'd3; pm = 3'd0;
    send(8'hA5, 8, 0, 0, 1, 1); hold(1'b1, 20);
    chk(recv.size() == 1, "R3", "count 8N1", recv.size(), 1);
    expect_char(0, 8'hA5, 0, 0, 0, "R3");

    // every word length, upper line bits high
    for (int w = 0; w < 4; w++) begin
      recv.delete(); wl = 2'(w);
      send(8'hFF, 5 + w, 0, 0, 1, 1); hold(1'b1, 20);
      d = 8'((1 << (5 + w)) - 1);
      expect_char(0, d, 0, 0, 0, "R3");
      recv.delete();
      send(8'h16, 5 + w, 0, 0, 1, 1); hold(1'b1, 20);
      expect_char(0, 8'h16 & d, 0, 0, 0, "R3");
    end

    // parity modes, matching and flipped
    for (int m = 1; m <= 4; m++) begin
      pm = 3'(m); wl = 2'd2;
      recv.delete();
      send(8'h35, 7, 1, ref_par(8'h35, 3'(m)), 1, 1); hold(1'b1, 20);
      expect_char(0, 8'h35, 0, 0, 0, "R4");
      recv.delete();
      send(8'h35, 7, 1, ~ref_par(8'h35, 3'(m)), 1, 1); hold(1'b1, 20);
      expect_char(0, 8'h35, 1, 0, 0, "R4");
    end
    recv.delete(); pm = 3'd1; wl = 2'd0;
    send(8'h13, 5, 1, 1, 1, 1); hold(1'b1, 20);
    expect_char(0, 8'h13, 1, 0, 0, "R4");
    recv.delete(); pm = 3'd7; wl = 2'd3;
    send(8'h5A, 8, 0, 0, 1, 1); hold(1'b1, 20);
    expect_char(0, 8'h5A, 0, 0, 0, "R4");

    // framing error then resync on the low stop bit
    recv.delete(); pm = 3'd0; wl = 2'd3;
    send(8'h3C, 8, 0, 0, 0, 1);
    send(8'h5A, 8, 0, 0, 1, 0); hold(1'b1, 20);
    chk(recv.size() == 2, "R6", "count after resync", recv.size(), 2);
    expect_char(0, 8'h3C, 0, 1, 0, "R5");
    expect_char(1, 8'h5A, 0, 0, 0, "R6");

    // break, long low, recovery
    recv.delete(); pm = 3'd2; wl = 2'd3;
    hold(1'b0, 200);
    chk(recv.size() == 1, "R7", "break count", recv.size(), 1);
    expect_char(0, 8'h00, 0, 1, 1, "R7");
    hold(1'b0, 200);
    chk(recv.size() == 1, "R8", "no char while low", recv.size(), 1);
    hold(1'b1, 20);
    send(8'h81, 8, 1, ref_par(8'h81, 3'd2), 1, 1); hold(1'b1, 20);
    chk(recv.size() == 2, "R8", "count after break", recv.size(), 2);
    expect_char(1, 8'h81, 0, 0, 0, "R8");

    // start glitch
    recv.delete(); pm = 3'd0;
    hold(1'b0, 4); hold(1'b1, 40);
    chk(recv.size() == 0, "R2", "glitch ignored", recv.size(), 0);
    send(8'h0F, 8, 0, 0, 1, 1); hold(1'b1, 20);
    expect_char(0, 8'h0F, 0, 0, 0, "R2");

    // slower ticks, gated ticks, paused frame
    recv.delete(); tdiv = 3;
    send(8'hC3, 8, 0, 0, 1, 1); hold(1'b1, 20);
    expect_char(0, 8'hC3, 0, 0, 0, "R10");
    recv.delete();
    @(negedge clk); #3 tick_en = 1'b0;
    #1 rx = 1'b0;
    repeat (100) @(posedge clk);
    #1 rx = 1'b1;
    repeat (10) @(posedge clk);
    @(negedge clk); #3 tick_en = 1'b1;
    hold(1'b1, 40);
    chk(recv.size() == 0, "R10", "no char without ticks", recv.size(), 0);
    fork
      send(8'h69, 8, 0, 0, 1, 1);
      begin
        repeat (250) @(posedge clk);
        @(negedge clk); #3 tick_en = 1'b0;
        repeat (60) @(negedge clk);
        #3 tick_en = 1'b1;
      end
    join
    hold(1'b1, 20);
    chk(recv.size() == 1, "R10", "count paused frame", recv.size(), 1);
    expect_char(0, 8'h69, 0, 0, 0, "R10");

    // reset in mid-frame
    recv.delete(); tdiv = 1;
    hold(1'b0, 16);
    for (int i = 0; i < 4; i++) hold(1'b1, 16);
    #1 rx = 1'b1;
    do_reset();
    hold(1'b1, 20);
    send(8'h42, 8, 0, 0, 1, 1); hold(1'b1, 20);
    chk(recv.size() == 1, "R1", "count after reset", recv.size(), 1);
    expect_char(0, 8'h42, 0, 0, 0, "R1");

    finish_run();
  end

endmodule